// File: doc/BRIEF.md
# Two-Level Address Translation Lookup

This block translates virtual page numbers into physical frame numbers for an instruction fetch path and a data access path. Each path has its own small micro-TLB. Hardware alone fills these micro-TLBs, and software cannot read or write them. Behind both sits one larger fully associative joint TLB. Each joint entry covers an aligned pair of virtual pages, one even and one odd, and holds a separate frame and valid bit for each page.

Each path presents a request with a virtual page number and an address-space identifier, and holds it stable while the block stalls it. In every requesting cycle the block returns exactly one of three results: a translation, a stall, or a miss exception.

When a micro-TLB misses, the joint TLB is consulted and a hit is copied into that micro-TLB. On the data side the joint TLB search runs in the same cycle as the micro-TLB search. On the instruction side it starts one cycle later. This gives a miss penalty of one stall cycle for data and two for instructions.

Software loads the joint TLB through a single write port. Every write empties both micro-TLBs.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every joint entry is invalid and both micro-TLBs are empty, and all result outputs are low while no request is made. A data request on the empty block raises `d_miss_o` in its first cycle. An instruction request raises `i_stall_o` for one cycle and then `i_miss_o`.
- R2: A request that hits its micro-TLB returns the frame with the hit output high in the same cycle, with no stall. Per path, at most one of hit, stall and miss is high in a cycle, and none is high without a request.
- R3: A data request that misses the data micro-TLB but hits the joint TLB stalls for exactly 1 cycle. The request then hits with the frame taken from the joint entry.
- R4: An instruction request that misses the instruction micro-TLB but hits the joint TLB stalls for exactly 2 cycles and then hits.
- R5: A joint TLB miss raises the path's miss output instead of a translation. For data this happens in the first cycle with 0 stalls. For instructions it follows 1 stall cycle.
- R6: Bit 0 of the virtual page number selects the even half (bit 0 = 0, first frame) or the odd half (bit 0 = 1, second frame) of a joint entry. A selected half whose valid bit is clear counts as a miss.
- R7: A joint entry matches when its pair tag equals the virtual page number without bit 0, and either its identifier equals the request's or its global bit is set.
- R8: A joint TLB write empties both micro-TLBs, so the next request on either path goes back to the joint TLB and sees the newly written contents.
- R9: Each micro-TLB has 3 slots and fills them round-robin, starting from slot 0 after reset or after a flush. The fourth distinct page loaded evicts the first page loaded.
- R10: When the data path and a waiting instruction lookup both need the joint TLB in the same cycle, the data path goes first and the instruction lookup waits one more cycle, for 3 stall cycles in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| i_req_i | input | 1 | Instruction translation request |
| i_vpn_i | input | VPN_W | Instruction virtual page number |
| i_asid_i | input | ASID_W | Instruction address-space identifier |
| i_hit_o | output | 1 | Instruction translation valid |
| i_stall_o | output | 1 | Instruction request stalled |
| i_miss_o | output | 1 | Instruction TLB-miss exception |
| i_pfn_o | output | PFN_W | Instruction physical frame number |
| d_req_i | input | 1 | Data translation request |
| d_vpn_i | input | VPN_W | Data virtual page number |
| d_asid_i | input | ASID_W | Data address-space identifier |
| d_hit_o | output | 1 | Data translation valid |
| d_stall_o | output | 1 | Data request stalled |
| d_miss_o | output | 1 | Data TLB-miss exception |
| d_pfn_o | output | PFN_W | Data physical frame number |
| wr_i | input | 1 | Joint TLB write strobe |
| wr_idx_i | input | JIDX_W | Joint entry index to write |
| wr_vpn2_i | input | VPN_W-1 | Page-pair tag |
| wr_asid_i | input | ASID_W | Entry address-space identifier |
| wr_glob_i | input | 1 | Global bit, matches any identifier |
| wr_pfn0_i | input | PFN_W | Even-page frame |
| wr_v0_i | input | 1 | Even-page valid |
| wr_pfn1_i | input | PFN_W | Odd-page frame |
| wr_v1_i | input | 1 | Odd-page valid |

## Verification
The bench builds the block with 12-bit page and frame numbers, 6-bit identifiers, 8 joint entries and 3-slot micro-TLBs. These narrow fields keep the tags and frames easy to read in messages. With three slots, a short run of four distinct pages reaches the round-robin wrap and the eviction of the oldest slot. The bench staggers an instruction miss one cycle ahead of a data miss, so the arbitration case arises with the instruction lookup already waiting on the joint TLB.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    I_IDLE = 1'b0,
    I_WAIT = 1'b1
  } ifetch_state_e;

  function automatic int ptr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tlb_micro.sv
module tlb_micro #(
  parameter int N      = 3,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              hit_o,
  output logic [PFN_W-1:0]  pfn_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_glob_i,
  input  logic [PFN_W-1:0]  fill_pfn_i
);
  localparam int PTR_W = tlb_pkg::ptr_width(N);

  logic [N-1:0]      vld_q;
  logic [N-1:0]      glob_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [PTR_W-1:0]  ptr_q;
  logic [N-1:0]      match;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn_i) &&
                      (glob_q[g] || (asid_q[g] == lk_asid_i));
  end

  always_comb begin
    pfn_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (match[k]) pfn_o = pfn_q[k];
    end
  end

  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      glob_q <= '0;
      ptr_q  <= '0;
      for (int k = 0; k < N; k++) begin
        vpn_q[k]  <= '0;
        asid_q[k] <= '0;
        pfn_q[k]  <= '0;
      end
    end else if (flush_i) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (fill_i) begin
      vld_q[ptr_q]  <= 1'b1;
      glob_q[ptr_q] <= fill_glob_i;
      vpn_q[ptr_q]  <= fill_vpn_i;
      asid_q[ptr_q] <= fill_asid_i;
      pfn_q[ptr_q]  <= fill_pfn_i;
      ptr_q         <= (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_joint.sv
module tlb_joint #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = tlb_pkg::ptr_width(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-2:0]  wr_vpn2_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_glob_i,
  input  logic [PFN_W-1:0]  wr_pfn0_i,
  input  logic              wr_v0_i,
  input  logic [PFN_W-1:0]  wr_pfn1_i,
  input  logic              wr_v1_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              hit_o,
  output logic              glob_o,
  output logic [PFN_W-1:0]  pfn_o
);
  logic [VPN_W-2:0]  vpn2_q [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn0_q [N];
  logic [PFN_W-1:0]  pfn1_q [N];
  logic [N-1:0]      glob_q, v0_q, v1_q;
  logic [N-1:0]      match;
  logic              odd;

  assign odd = lk_vpn_i[0];

  for (genvar g = 0; g < N; g++) begin : g_match
    assign match[g] = (vpn2_q[g] == lk_vpn_i[VPN_W-1:1]) &&
                      (glob_q[g] || (asid_q[g] == lk_asid_i));
  end

  // lowest matching index wins; the selected half must be valid
  always_comb begin
    hit_o  = 1'b0;
    glob_o = 1'b0;
    pfn_o  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o  = odd ? v1_q[k] : v0_q[k];
        glob_o = glob_q[k];
        pfn_o  = odd ? pfn1_q[k] : pfn0_q[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q <= '0;
      v0_q   <= '0;
      v1_q   <= '0;
      for (int k = 0; k < N; k++) begin
        vpn2_q[k] <= '0;
        asid_q[k] <= '0;
        pfn0_q[k] <= '0;
        pfn1_q[k] <= '0;
      end
    end else if (wr_i) begin
      vpn2_q[wr_idx_i] <= wr_vpn2_i;
      asid_q[wr_idx_i] <= wr_asid_i;
      glob_q[wr_idx_i] <= wr_glob_i;
      pfn0_q[wr_idx_i] <= wr_pfn0_i;
      v0_q[wr_idx_i]   <= wr_v0_i;
      pfn1_q[wr_idx_i] <= wr_pfn1_i;
      v1_q[wr_idx_i]   <= wr_v1_i;
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int JTLB_N  = 16,
  parameter int UTLB_N  = 3,
  localparam int JIDX_W = tlb_pkg::ptr_width(JTLB_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              i_req_i,
  input  logic [VPN_W-1:0]  i_vpn_i,
  input  logic [ASID_W-1:0] i_asid_i,
  output logic              i_hit_o,
  output logic              i_stall_o,
  output logic              i_miss_o,
  output logic [PFN_W-1:0]  i_pfn_o,
  input  logic              d_req_i,
  input  logic [VPN_W-1:0]  d_vpn_i,
  input  logic [ASID_W-1:0] d_asid_i,
  output logic              d_hit_o,
  output logic              d_stall_o,
  output logic              d_miss_o,
  output logic [PFN_W-1:0]  d_pfn_o,
  input  logic              wr_i,
  input  logic [JIDX_W-1:0] wr_idx_i,
  input  logic [VPN_W-2:0]  wr_vpn2_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_glob_i,
  input  logic [PFN_W-1:0]  wr_pfn0_i,
  input  logic              wr_v0_i,
  input  logic [PFN_W-1:0]  wr_pfn1_i,
  input  logic              wr_v1_i
);
  import tlb_pkg::*;

  logic              i_uhit, d_uhit;
  logic              d_jt_need, i_jt_need, i_grant;
  logic              i_fill, d_fill;
  logic [VPN_W-1:0]  jt_vpn;
  logic [ASID_W-1:0] jt_asid;
  logic              jt_hit, jt_glob;
  logic [PFN_W-1:0]  jt_pfn;
  ifetch_state_e     i_state_q, i_state_d;

  tlb_micro #(.N(UTLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_itlb (
    .clk_i, .rst_ni, .flush_i(wr_i),
    .lk_vpn_i(i_vpn_i), .lk_asid_i(i_asid_i), .hit_o(i_uhit), .pfn_o(i_pfn_o),
    .fill_i(i_fill), .fill_vpn_i(i_vpn_i), .fill_asid_i(i_asid_i),
    .fill_glob_i(jt_glob), .fill_pfn_i(jt_pfn)
  );

  tlb_micro #(.N(UTLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_dtlb (
    .clk_i, .rst_ni, .flush_i(wr_i),
    .lk_vpn_i(d_vpn_i), .lk_asid_i(d_asid_i), .hit_o(d_uhit), .pfn_o(d_pfn_o),
    .fill_i(d_fill), .fill_vpn_i(d_vpn_i), .fill_asid_i(d_asid_i),
    .fill_glob_i(jt_glob), .fill_pfn_i(jt_pfn)
  );

  tlb_joint #(.N(JTLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_jtlb (
    .clk_i, .rst_ni,
    .wr_i, .wr_idx_i, .wr_vpn2_i, .wr_asid_i, .wr_glob_i,
    .wr_pfn0_i, .wr_v0_i, .wr_pfn1_i, .wr_v1_i,
    .lk_vpn_i(jt_vpn), .lk_asid_i(jt_asid),
    .hit_o(jt_hit), .glob_o(jt_glob), .pfn_o(jt_pfn)
  );

  // data searches the joint TLB alongside its micro-TLB; instruction waits a cycle
  assign d_jt_need = d_req_i && !d_uhit;
  assign i_jt_need = i_req_i && !i_uhit && (i_state_q == I_WAIT);
  assign i_grant   = i_jt_need && !d_jt_need;

  assign jt_vpn  = d_jt_need ? d_vpn_i  : i_vpn_i;
  assign jt_asid = d_jt_need ? d_asid_i : i_asid_i;

  // a joint write in the same cycle wins over any refill
  assign d_fill = d_jt_need && jt_hit && !wr_i;
  assign i_fill = i_grant   && jt_hit && !wr_i;

  assign d_hit_o   = d_req_i && d_uhit;
  assign d_stall_o = d_jt_need && jt_hit;
  assign d_miss_o  = d_jt_need && !jt_hit;

  assign i_hit_o   = i_req_i && i_uhit;
  assign i_miss_o  = i_grant && !jt_hit;
  assign i_stall_o = i_req_i && !i_uhit && !i_miss_o;

  always_comb begin
    i_state_d = i_state_q;
    unique case (i_state_q)
      I_IDLE: if (i_req_i && !i_uhit) i_state_d = I_WAIT;
      I_WAIT: if (!i_req_i || i_uhit || i_grant) i_state_d = I_IDLE;
      default: i_state_d = I_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) i_state_q <= I_IDLE;
    else         i_state_q <= i_state_d;
  end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              i_req_i,
  input logic [VPN_W-1:0]  i_vpn_i,
  input logic [ASID_W-1:0] i_asid_i,
  input logic              i_hit_o,
  input logic              i_stall_o,
  input logic              i_miss_o,
  input logic              d_req_i,
  input logic [VPN_W-1:0]  d_vpn_i,
  input logic [ASID_W-1:0] d_asid_i,
  input logic              d_hit_o,
  input logic              d_stall_o,
  input logic              d_miss_o,
  input logic              wr_i
);
  AST_I_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({i_hit_o, i_stall_o, i_miss_o})); // R2
  AST_D_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({d_hit_o, d_stall_o, d_miss_o})); // R2
  AST_QUIET_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!d_req_i |-> !(d_hit_o || d_stall_o || d_miss_o)) and
    (!i_req_i |-> !(i_hit_o || i_stall_o || i_miss_o))); // R2
  AST_D_SINGLE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_stall_o && !wr_i |=> (!d_req_i || d_vpn_i != $past(d_vpn_i) ||
                            d_asid_i != $past(d_asid_i) || d_hit_o)); // R3
  AST_I_NO_EARLY_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(i_stall_o) |=> (!i_req_i || i_vpn_i != $past(i_vpn_i) ||
                          i_asid_i != $past(i_asid_i) || !i_hit_o)); // R4
  AST_I_MISS_AFTER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_miss_o |-> $past(i_stall_o)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i) |-> !i_hit_o && !d_hit_o); // R8
endmodule

bind xlat_tlb xlat_tlb_chk #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .i_req_i(i_req_i), .i_vpn_i(i_vpn_i), .i_asid_i(i_asid_i),
  .i_hit_o(i_hit_o), .i_stall_o(i_stall_o), .i_miss_o(i_miss_o),
  .d_req_i(d_req_i), .d_vpn_i(d_vpn_i), .d_asid_i(d_asid_i),
  .d_hit_o(d_hit_o), .d_stall_o(d_stall_o), .d_miss_o(d_miss_o),
  .wr_i(wr_i)
);

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
  localparam int VW = 12, PW = 12, AW = 6, JN = 8, UN = 3, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          i_req = 0, d_req = 0, wr = 0;
  logic [VW-1:0] i_vpn = '0, d_vpn = '0;
  logic [AW-1:0] i_asid = '0, d_asid = '0, wr_asid = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [VW-2:0] wr_vpn2 = '0;
  logic          wr_glob = 0, wr_v0 = 0, wr_v1 = 0;
  logic [PW-1:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic          i_hit, i_stall, i_miss, d_hit, d_stall, d_miss;
  logic [PW-1:0] i_pfn, d_pfn;

  int checks = 0, fails = 0;
  bit over = 0;

  xlat_tlb #(.VPN_W(VW), .PFN_W(PW), .ASID_W(AW), .JTLB_N(JN), .UTLB_N(UN)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .i_req_i(i_req), .i_vpn_i(i_vpn), .i_asid_i(i_asid),
    .i_hit_o(i_hit), .i_stall_o(i_stall), .i_miss_o(i_miss), .i_pfn_o(i_pfn),
    .d_req_i(d_req), .d_vpn_i(d_vpn), .d_asid_i(d_asid),
    .d_hit_o(d_hit), .d_stall_o(d_stall), .d_miss_o(d_miss), .d_pfn_o(d_pfn),
    .wr_i(wr), .wr_idx_i(wr_idx), .wr_vpn2_i(wr_vpn2), .wr_asid_i(wr_asid),
    .wr_glob_i(wr_glob), .wr_pfn0_i(wr_pfn0), .wr_v0_i(wr_v0),
    .wr_pfn1_i(wr_pfn1), .wr_v1_i(wr_v1)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic jwrite(input int idx, input int vpn2, input int asid, input bit g,
                        input int p0, input bit v0, input int p1, input bit v1);
    @(negedge clk);
    wr = 1; wr_idx = IW'(idx); wr_vpn2 = (VW-1)'(vpn2); wr_asid = AW'(asid);
    wr_glob = g; wr_pfn0 = PW'(p0); wr_v0 = v0; wr_pfn1 = PW'(p1); wr_v1 = v1;
    @(negedge clk);
    wr = 0;
  endtask

  // one request on one path; counts stall cycles up to the outcome
  task automatic access(input bit is_d, input int vpn, input int asid,
                        input int exp_st, input bit exp_miss, input int exp_pfn,
                        input string tag);
    int n = 0;
    bit done = 0, got_miss = 0, bad = 0;
    logic [PW-1:0] pfn = '0;
    @(negedge clk);
    if (is_d) begin d_req = 1; d_vpn = VW'(vpn); d_asid = AW'(asid); end
    else      begin i_req = 1; i_vpn = VW'(vpn); i_asid = AW'(asid); end
    for (int c = 0; c < 8 && !done; c++) begin
      #1;
      if (is_d ? d_hit : i_hit) begin
        done = 1; pfn = is_d ? d_pfn : i_pfn;
      end else if (is_d ? d_miss : i_miss) begin
        done = 1; got_miss = 1;
      end else begin
        if (is_d ? d_stall : i_stall) n++;
        else bad = 1;
        @(negedge clk);
      end
    end
    @(negedge clk);
    d_req = 0; i_req = 0;
    check(done && !bad && n == exp_st && got_miss == exp_miss &&
          (exp_miss || pfn == PW'(exp_pfn)), tag,
          $sformatf("stalls=%0d miss=%0b pfn=%h", n, got_miss, pfn),
          $sformatf("stalls=%0d miss=%0b pfn=%h", exp_st, exp_miss, PW'(exp_pfn)));
  endtask

  task automatic t_reset();
    #1;
    check({i_hit, i_stall, i_miss, d_hit, d_stall, d_miss} == 6'b0, "R1 idle outputs",
          $sformatf("%b", {i_hit, i_stall, i_miss, d_hit, d_stall, d_miss}), "000000");
    access(1, 'h020, 1, 0, 1, 0, "R1 data on empty");
    access(0, 'h020, 1, 1, 1, 0, "R1 instr on empty");
  endtask

  task automatic t_load();
    jwrite(0, 'h010, 1, 0, 'h111, 1, 'h222, 1);
    jwrite(1, 'h011, 2, 0, 'h333, 1, 'h3ff, 0);
    jwrite(2, 'h012, 0, 1, 'h444, 1, 'h555, 1);
    jwrite(3, 'h013, 1, 0, 'h600, 1, 'h601, 1);
    jwrite(4, 'h014, 1, 0, 'h602, 1, 'h603, 1);
  endtask

  task automatic t_data();
    access(1, 'h020, 1, 1, 0, 'h111, "R3 data refill even");
    access(1, 'h020, 1, 0, 0, 'h111, "R2 data micro hit");
    access(1, 'h021, 1, 1, 0, 'h222, "R6 data odd half");
  endtask

  task automatic t_instr();
    access(0, 'h021, 1, 2, 0, 'h222, "R4 instr refill");
    access(0, 'h021, 1, 0, 0, 'h222, "R2 instr micro hit");
  endtask

  task automatic t_match();
    access(1, 'h020, 2, 0, 1, 0, "R7 identifier mismatch");
    access(1, 'h024, 5, 1, 0, 'h444, "R7 global any identifier");
    access(0, 'h025, 3, 2, 0, 'h555, "R7 global instr odd");
    access(1, 'h023, 2, 0, 1, 0, "R6 invalid odd half");
    access(1, 'h022, 2, 1, 0, 'h333, "R6 valid even half");
    access(0, 'h023, 2, 1, 1, 0, "R5 instr joint miss");
  endtask

  task automatic t_flush();
    jwrite(0, 'h010, 1, 0, 'h1aa, 1, 'h222, 1);
    access(1, 'h020, 1, 1, 0, 'h1aa, "R8 data sees new frame");
    access(0, 'h021, 1, 2, 0, 'h222, "R8 instr refetches");
  endtask

  task automatic t_rr();
    jwrite(3, 'h013, 1, 0, 'h600, 1, 'h601, 1);
    access(1, 'h026, 1, 1, 0, 'h600, "R9 fill slot0");
    access(1, 'h027, 1, 1, 0, 'h601, "R9 fill slot1");
    access(1, 'h028, 1, 1, 0, 'h602, "R9 fill slot2");
    access(1, 'h026, 1, 0, 0, 'h600, "R9 slot0 retained");
    access(1, 'h029, 1, 1, 0, 'h603, "R9 wrap evicts slot0");
    access(1, 'h027, 1, 0, 0, 'h601, "R9 slot1 retained");
    access(1, 'h026, 1, 1, 0, 'h600, "R9 oldest was evicted");
    access(1, 'h028, 1, 0, 0, 'h602, "R9 slot2 retained");
  endtask

  task automatic t_conflict();
    jwrite(4, 'h014, 1, 0, 'h602, 1, 'h603, 1);
    @(negedge clk);
    i_req = 1; i_vpn = 'h026; i_asid = 1;
    #1 check(i_stall, "R10 c0 instr stall", $sformatf("%b", i_stall), "1");
    @(negedge clk);
    d_req = 1; d_vpn = 'h028; d_asid = 1;
    #1 check(i_stall && d_stall, "R10 c1 both stall",
             $sformatf("%b%b", i_stall, d_stall), "11");
    @(negedge clk);
    #1 check(i_stall && d_hit && d_pfn == 'h602, "R10 c2 data first",
             $sformatf("is=%b dh=%b pfn=%h", i_stall, d_hit, d_pfn), "is=1 dh=1 pfn=602");
    @(negedge clk);
    d_req = 0;
    #1 check(i_hit && i_pfn == 'h600, "R10 c3 instr after 3 stalls",
             $sformatf("ih=%b pfn=%h", i_hit, i_pfn), "ih=1 pfn=600");
    @(negedge clk);
    i_req = 0;
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load();
    t_data();
    t_instr();
    t_match();
    t_flush();
    t_rr();
    t_conflict();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule